// File: doc/BRIEF.md
# Two-Port Instruction Tag Check

This block sits behind the metadata read of a set-associative instruction cache. For each of its two ports it takes a physical request tag and set index plus the tags, entry-valid bits and one-bit check codes that the metadata arrays returned for every way. It then decides which way holds the line and whether the metadata can be trusted. The first port always covers the fetch's own cache line. The second port covers the following line and is only meaningful when the fetch crosses a line boundary.

A refill that is being written into the arrays in the same cycle can make the array read stale. The block watches the refill write and patches its result so the outcome matches the arrays as they will be, with no second read. Metadata corruption covers two cases: more than one way hitting, and a single hit whose stored code disagrees with the code recomputed from the request tag. While checking is enabled, corruption is reported as an access-fault exception. All results are registered and appear one cycle after the lookup strobe.

Top module: `fetch_tag_check`

## Requirements
- R1: Way w of port p hits when its stored tag equals the port's request tag and its entry-valid bit is set; the hit bit sits at way_mask_o[p*WAYS+w], and hit_o[p] is the OR of that port's mask bits.
- R2: res_vld_o is high in the cycle after lookup_vld_i was high with flush_i low, and low otherwise (including after reset); result fields load on every lookup.
- R3: When cross_line_i is low, port 1 reports an all-zero mask, code 0, no hit and exception 00, whatever its inputs.
- R4: code_o[p] is the stored code of the way selected by the port's mask (OR of code bits under the mask), and 0 when the mask is empty.
- R5: A port whose mask has two or more bits set is corrupt, regardless of the codes.
- R6: A port with exactly one mask bit set is corrupt when the even-parity bit (XOR of all tag bits) of its request tag differs from code_o[p].
- R7: A port whose final mask is empty is never corrupt.
- R8: excp_o[2p+1:2p] is 2'b01 (access fault) for a corrupt port while ecc_en_i is high, and 2'b00 (none) otherwise.
- R9: A refill that is valid, not marked corrupt, on the port's set, with a tag equal to the request tag, replaces the mask with refill_mask_i and the code with the parity of the request tag.
- R10: A refill that is valid, not marked corrupt, on the port's set, with a different tag but refill_mask_i equal to the looked-up mask, clears the mask to zero.
- R11: A refill marked corrupt, or one on a different set, leaves the looked-up mask and code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drops the result of the lookup presented this cycle |
| lookup_vld_i | input | 1 | Lookup inputs are valid |
| cross_line_i | input | 1 | Fetch crosses into the next line; enables port 1 |
| ecc_en_i | input | 1 | Enables the corruption exception |
| req_tag_i | input | 2*TAG_W | Request physical tag per port |
| req_set_i | input | 2*SET_W | Request set index per port |
| meta_tag_i | input | 2*WAYS*TAG_W | Stored tags, port-major then way |
| meta_vld_i | input | 2*WAYS | Stored entry-valid bits |
| meta_code_i | input | 2*WAYS | Stored check codes, one bit per way |
| refill_vld_i | input | 1 | Refill write in progress |
| refill_corrupt_i | input | 1 | Refill data flagged corrupt |
| refill_set_i | input | SET_W | Refill set index |
| refill_tag_i | input | TAG_W | Refill physical tag |
| refill_mask_i | input | WAYS | Way being written by the refill |
| res_vld_o | output | 1 | Result valid |
| way_mask_o | output | 2*WAYS | Final way mask per port |
| code_o | output | 2 | Selected check code per port |
| hit_o | output | 2 | Hit per port |
| excp_o | output | 4 | Exception per port, 00 none, 01 access fault |

## Verification
The assertions watch every cycle for the result strobe following the lookup and flush, for port 1 staying silent on non-crossing fetches, for a multi-way hit turning into an access fault when checking is on, for no fault while checking is off, and for the hit flag agreeing with its mask. Whether the right way is chosen, whether a single-hit parity mismatch is caught, and whether refill patching replaces, clears or ignores correctly depend on tag values, so only the bench's reference model can confirm them, through directed cases for each refill outcome and a long run of randomised tag pools.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int unsigned NPORT = 2;
  typedef enum logic [1:0] {
    EXC_NONE = 2'b00,
    EXC_AF   = 2'b01
  } exc_e;
endpackage

// File: rtl/ftc_way_match.sv
module ftc_way_match #(
  parameter int unsigned TAG_W = 20,
  parameter int unsigned WAYS  = 4
) (
  input  logic [TAG_W-1:0]      req_tag_i,
  input  logic [WAYS*TAG_W-1:0] meta_tag_i,
  input  logic [WAYS-1:0]       meta_vld_i,
  input  logic [WAYS-1:0]       meta_code_i,
  output logic [WAYS-1:0]       mask_o,
  output logic                  code_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign mask_o[w] = meta_vld_i[w] && (meta_tag_i[w*TAG_W +: TAG_W] == req_tag_i);
  end
  // one-hot select of the stored code
  assign code_o = |(mask_o & meta_code_i);
endmodule

// File: rtl/ftc_refill_patch.sv
module ftc_refill_patch #(
  parameter int unsigned TAG_W = 20,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SET_W = 6
) (
  input  logic [WAYS-1:0]  mask_i,
  input  logic             code_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic [SET_W-1:0] req_set_i,
  input  logic             refill_vld_i,
  input  logic             refill_corrupt_i,
  input  logic [SET_W-1:0] refill_set_i,
  input  logic [TAG_W-1:0] refill_tag_i,
  input  logic [WAYS-1:0]  refill_mask_i,
  output logic [WAYS-1:0]  mask_o,
  output logic             code_o
);
  logic same_set;
  assign same_set = refill_vld_i && !refill_corrupt_i && (refill_set_i == req_set_i);

  always_comb begin
    mask_o = mask_i;
    code_o = code_i;
    if (same_set) begin
      if (refill_tag_i == req_tag_i) begin
        mask_o = refill_mask_i;
        code_o = ^req_tag_i;
      end else if (refill_mask_i == mask_i) begin
        mask_o = '0;
      end
    end
  end
endmodule

// File: rtl/ftc_corrupt_chk.sv
module ftc_corrupt_chk
  import ftc_pkg::*;
#(
  parameter int unsigned TAG_W = 20,
  parameter int unsigned WAYS  = 4
) (
  input  logic [WAYS-1:0]  mask_i,
  input  logic             code_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             ecc_en_i,
  output logic             hit_o,
  output exc_e             excp_o
);
  localparam int unsigned CNT_W = $clog2(WAYS + 1);

  logic [CNT_W-1:0] n_hit;
  logic             corrupt;

  always_comb begin
    n_hit = '0;
    for (int w = 0; w < WAYS; w++) n_hit = n_hit + CNT_W'(mask_i[w]);
  end

  assign hit_o   = |mask_i;
  assign corrupt = (n_hit > CNT_W'(1)) ||
                   ((n_hit == CNT_W'(1)) && ((^req_tag_i) != code_i));
  assign excp_o  = (corrupt && ecc_en_i) ? EXC_AF : EXC_NONE;
endmodule

// File: rtl/fetch_tag_check.sv
module fetch_tag_check
  import ftc_pkg::*;
#(
  parameter int unsigned TAG_W = 20,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SET_W = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic                        lookup_vld_i,
  input  logic                        cross_line_i,
  input  logic                        ecc_en_i,
  input  logic [2*TAG_W-1:0]          req_tag_i,
  input  logic [2*SET_W-1:0]          req_set_i,
  input  logic [2*WAYS*TAG_W-1:0]     meta_tag_i,
  input  logic [2*WAYS-1:0]           meta_vld_i,
  input  logic [2*WAYS-1:0]           meta_code_i,
  input  logic                        refill_vld_i,
  input  logic                        refill_corrupt_i,
  input  logic [SET_W-1:0]            refill_set_i,
  input  logic [TAG_W-1:0]            refill_tag_i,
  input  logic [WAYS-1:0]             refill_mask_i,
  output logic                        res_vld_o,
  output logic [2*WAYS-1:0]           way_mask_o,
  output logic [1:0]                  code_o,
  output logic [1:0]                  hit_o,
  output logic [3:0]                  excp_o
);
  logic [NPORT*WAYS-1:0] mask_d;
  logic [NPORT-1:0]      code_d, hit_d;
  logic [2*NPORT-1:0]    excp_d;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [WAYS-1:0] raw_mask, fix_mask;
    logic            raw_code, fix_code, hit;
    exc_e            excp;
    logic            port_en;

    assign port_en = (p == 0) ? 1'b1 : cross_line_i;

    ftc_way_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
      .req_tag_i  (req_tag_i[p*TAG_W +: TAG_W]),
      .meta_tag_i (meta_tag_i[p*WAYS*TAG_W +: WAYS*TAG_W]),
      .meta_vld_i (meta_vld_i[p*WAYS +: WAYS]),
      .meta_code_i(meta_code_i[p*WAYS +: WAYS]),
      .mask_o     (raw_mask),
      .code_o     (raw_code)
    );

    ftc_refill_patch #(.TAG_W(TAG_W), .WAYS(WAYS), .SET_W(SET_W)) u_patch (
      .mask_i          (raw_mask),
      .code_i          (raw_code),
      .req_tag_i       (req_tag_i[p*TAG_W +: TAG_W]),
      .req_set_i       (req_set_i[p*SET_W +: SET_W]),
      .refill_vld_i    (refill_vld_i),
      .refill_corrupt_i(refill_corrupt_i),
      .refill_set_i    (refill_set_i),
      .refill_tag_i    (refill_tag_i),
      .refill_mask_i   (refill_mask_i),
      .mask_o          (fix_mask),
      .code_o          (fix_code)
    );

    ftc_corrupt_chk #(.TAG_W(TAG_W), .WAYS(WAYS)) u_chk (
      .mask_i   (fix_mask),
      .code_i   (fix_code),
      .req_tag_i(req_tag_i[p*TAG_W +: TAG_W]),
      .ecc_en_i (ecc_en_i),
      .hit_o    (hit),
      .excp_o   (excp)
    );

    assign mask_d[p*WAYS +: WAYS] = port_en ? fix_mask : '0;
    assign code_d[p]              = port_en && fix_code;
    assign hit_d[p]               = port_en && hit;
    assign excp_d[2*p +: 2]       = port_en ? excp : EXC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o  <= 1'b0;
      way_mask_o <= '0;
      code_o     <= '0;
      hit_o      <= '0;
      excp_o     <= '0;
    end else begin
      res_vld_o <= lookup_vld_i && !flush_i;
      if (lookup_vld_i) begin
        way_mask_o <= mask_d;
        code_o     <= code_d;
        hit_o      <= hit_d;
        excp_o     <= excp_d;
      end
    end
  end
endmodule

// File: rtl/fetch_tag_check_chk.sv
module fetch_tag_check_chk #(
  parameter int unsigned WAYS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              lookup_vld_i,
  input logic              cross_line_i,
  input logic              ecc_en_i,
  input logic              res_vld_o,
  input logic [2*WAYS-1:0] way_mask_o,
  input logic [1:0]        hit_o,
  input logic [3:0]        excp_o
);
  // R2
  res_vld_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_vld_i && !flush_i) |=> res_vld_o);
  // R2
  flush_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i || !lookup_vld_i) |=> !res_vld_o);
  // R3
  port1_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_vld_i && !cross_line_i) |=>
      (way_mask_o[2*WAYS-1:WAYS] == '0 && !hit_o[1] && excp_o[3:2] == 2'b00));
  // R5
  multi_hit_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_vld_i && ecc_en_i) |=>
      (($countones(way_mask_o[WAYS-1:0]) < 2) || excp_o[1:0] == 2'b01));
  // R8
  ecc_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_vld_i && !ecc_en_i) |=> (excp_o == 4'b0000));
  // R1
  hit_vs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> (hit_o[0] == (way_mask_o[WAYS-1:0] != '0)));
endmodule

bind fetch_tag_check fetch_tag_check_chk #(.WAYS(WAYS)) u_chk_bind (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .lookup_vld_i(lookup_vld_i),
  .cross_line_i(cross_line_i),
  .ecc_en_i    (ecc_en_i),
  .res_vld_o   (res_vld_o),
  .way_mask_o  (way_mask_o),
  .hit_o       (hit_o),
  .excp_o      (excp_o)
);

// File: tb/fetch_tag_check_bench.sv
`timescale 1ns/1ps
module fetch_tag_check_bench;
  localparam int TW = 20;
  localparam int NW = 4;
  localparam int SW = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 0, lookup_vld_i = 0, cross_line_i = 0, ecc_en_i = 0;
  logic [2*TW-1:0]    req_tag_i = '0;
  logic [2*SW-1:0]    req_set_i = '0;
  logic [2*NW*TW-1:0] meta_tag_i = '0;
  logic [2*NW-1:0]    meta_vld_i = '0, meta_code_i = '0;
  logic refill_vld_i = 0, refill_corrupt_i = 0;
  logic [SW-1:0] refill_set_i = '0;
  logic [TW-1:0] refill_tag_i = '0;
  logic [NW-1:0] refill_mask_i = '0;
  logic res_vld_o;
  logic [2*NW-1:0] way_mask_o;
  logic [1:0] code_o, hit_o;
  logic [3:0] excp_o;

  int total = 0, bad = 0;
  logic [TW-1:0] pool [4];

  fetch_tag_check #(.TAG_W(TW), .WAYS(NW), .SET_W(SW)) u_fetch_tag_check (.*);

  always #2.5 clk_i = ~clk_i;

  // reference model state
  logic e_vld = 0;
  logic [2*NW-1:0] e_mask = '0;
  logic [1:0] e_code = '0, e_hit = '0;
  logic [3:0] e_excp = '0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_vld = 0; e_mask = '0; e_code = '0; e_hit = '0; e_excp = '0;
    end else begin
      e_vld = lookup_vld_i && !flush_i;
      if (lookup_vld_i) begin
        for (int p = 0; p < 2; p++) begin
          logic [NW-1:0] m;
          logic c, corrupt;
          logic [TW-1:0] t;
          int n;
          t = req_tag_i[p*TW +: TW];
          m = '0; c = 0;
          for (int w = 0; w < NW; w++)
            if (meta_vld_i[p*NW+w] && meta_tag_i[(p*NW+w)*TW +: TW] == t) begin
              m[w] = 1; c = c | meta_code_i[p*NW+w];
            end
          if (refill_vld_i && !refill_corrupt_i && refill_set_i == req_set_i[p*SW +: SW]) begin
            if (refill_tag_i == t) begin m = refill_mask_i; c = ^t; end
            else if (refill_mask_i == m) m = '0;
          end
          n = 0;
          for (int w = 0; w < NW; w++) n += m[w];
          corrupt = (n > 1) || (n == 1 && c != ^t);
          if (p == 1 && !cross_line_i) begin m = '0; c = 0; corrupt = 0; end
          e_mask[p*NW +: NW] = m;
          e_code[p] = c;
          e_hit[p] = (m != 0);
          e_excp[2*p +: 2] = (corrupt && ecc_en_i) ? 2'b01 : 2'b00;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 res_vld", 32'(res_vld_o), 32'(e_vld));
    if (e_vld) begin
      chk("R1,R3,R9,R10,R11 mask", 32'(way_mask_o), 32'(e_mask));
      chk("R4,R9 code", 32'(code_o), 32'(e_code));
      chk("R1 hit", 32'(hit_o), 32'(e_hit));
      chk("R5,R6,R7,R8 excp", 32'(excp_o), 32'(e_excp));
    end
  endtask

  task automatic set_way(input int p, input int w, input logic [TW-1:0] t,
                         input logic v, input logic c);
    meta_tag_i[(p*NW+w)*TW +: TW] = t;
    meta_vld_i[p*NW+w] = v;
    meta_code_i[p*NW+w] = c;
  endtask

  task automatic clear_meta();
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < NW; w++) set_way(p, w, 20'h0F0F0 + TW'(p*NW+w), 1'b1, 1'b0);
    refill_vld_i = 0; refill_corrupt_i = 0;
  endtask

  // one lookup cycle; compares model at the following negedge
  task automatic step();
    lookup_vld_i = 1;
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
    lookup_vld_i = 0; flush_i = 0;
  endtask

  initial begin
    pool[0] = 20'hABCDE; pool[1] = 20'h12345; pool[2] = 20'h7F00F; pool[3] = 20'h00C01;
    repeat (3) @(negedge clk_i);
    chk("R2 reset vld", 32'(res_vld_o), 0);
    chk("R2 reset mask", 32'(way_mask_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    ecc_en_i = 1; cross_line_i = 1;
    req_tag_i = {pool[1], pool[0]};
    req_set_i = {6'd9, 6'd8};

    // R1 R4 single clean hit way 2
    clear_meta();
    set_way(0, 2, pool[0], 1, ^pool[0]);
    set_way(0, 1, pool[0], 0, 1'b1);
    step();
    chk("R1 single hit mask", 32'(way_mask_o[3:0]), 32'h4);
    chk("R4 code select", 32'(code_o[0]), 32'(^pool[0]));
    chk("R6 clean hit no fault", 32'(excp_o[1:0]), 0);

    // R5 multi hit
    clear_meta();
    set_way(0, 0, pool[0], 1, ^pool[0]);
    set_way(0, 3, pool[0], 1, ^pool[0]);
    step();
    chk("R5 multi hit fault", 32'(excp_o[1:0]), 32'h1);

    // R6 single hit bad code, on port 1
    clear_meta();
    set_way(1, 1, pool[1], 1, ~^pool[1]);
    step();
    chk("R6 parity fault", 32'(excp_o[3:2]), 32'h1);

    // R8 same with ecc off
    ecc_en_i = 0;
    step();
    chk("R8 ecc off", 32'(excp_o), 0);
    ecc_en_i = 1;

    // R7 no hit, bad codes everywhere
    clear_meta();
    for (int w = 0; w < NW; w++) set_way(0, w, pool[2], 1, 1'b1);
    step();
    chk("R7 miss no fault", 32'(excp_o[1:0]), 0);

    // R3 port 1 forced off
    clear_meta();
    set_way(1, 0, pool[1], 1, 1'b1);
    set_way(1, 2, pool[1], 1, 1'b0);
    cross_line_i = 0;
    step();
    chk("R3 port1 mask", 32'(way_mask_o[7:4]), 0);
    chk("R3 port1 excp", 32'(excp_o[3:2]), 0);
    cross_line_i = 1;

    // R9 refill tag match replaces mask and code
    clear_meta();
    refill_vld_i = 1; refill_set_i = 6'd8; refill_tag_i = pool[0]; refill_mask_i = 4'b0010;
    step();
    chk("R9 refill mask", 32'(way_mask_o[3:0]), 32'h2);
    chk("R9 refill code", 32'(code_o[0]), 32'(^pool[0]));

    // R10 refill other tag same mask clears
    clear_meta();
    set_way(0, 3, pool[0], 1, ^pool[0]);
    refill_vld_i = 1; refill_set_i = 6'd8; refill_tag_i = pool[3]; refill_mask_i = 4'b1000;
    step();
    chk("R10 refill clears", 32'(way_mask_o[3:0]), 0);

    // R11 corrupt refill ignored, other set ignored
    refill_corrupt_i = 1;
    step();
    chk("R11 corrupt refill", 32'(way_mask_o[3:0]), 32'h8);
    refill_corrupt_i = 0; refill_set_i = 6'd5;
    step();
    chk("R11 other set", 32'(way_mask_o[3:0]), 32'h8);

    // R2 flush drops the result
    flush_i = 1;
    step();
    chk("R2 flush", 32'(res_vld_o), 0);
    @(negedge clk_i);
    compare();

    // random run with small tag pool
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < 2; p++) begin
        req_tag_i[p*TW +: TW] = pool[$urandom % 4];
        req_set_i[p*SW +: SW] = SW'($urandom % 3);
        for (int w = 0; w < NW; w++) begin
          logic [TW-1:0] t;
          t = pool[$urandom % 4];
          set_way(p, w, t, ($urandom % 4) != 0, (^t) ^ (($urandom % 6) == 0));
        end
      end
      refill_vld_i = ($urandom % 3) == 0;
      refill_corrupt_i = ($urandom % 4) == 0;
      refill_set_i = SW'($urandom % 3);
      refill_tag_i = pool[$urandom % 4];
      refill_mask_i = NW'($urandom % 16);
      cross_line_i = $urandom % 2;
      ecc_en_i = ($urandom % 5) != 0;
      flush_i = ($urandom % 10) == 0;
      lookup_vld_i = ($urandom % 4) != 0;
      @(posedge clk_i);
      @(negedge clk_i);
      compare();
    end
    lookup_vld_i = 0; flush_i = 0;
    @(negedge clk_i);
    compare();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule